// File: doc/BRIEF.md
# Background Byte-Write Sequencer for On-Chip Nonvolatile Data Memory

This block maps a small nonvolatile byte array into the external-data address space of a CPU. A control/status register has an enable bit. While that bit is set, external-data reads and writes whose address falls in the lowest 4 KB window (0x0000 to 0x0FFF) are steered to the array. The `xd_hit` output tells the surrounding fabric to suppress the external memory cycle. A write is accepted in a single cycle and then completes in the background: the target byte is first erased to 0xFF, then programmed with the new value. The CPU is never stalled. Software polls the busy flag and waits for it to clear before it issues the next access.

A brown-out input guards the array. A guard timer holds an inhibit flag for a programmable number of cycles after reset and after the last cycle in which brown-out was high. No write is accepted while the flag is set or while brown-out is high. If brown-out rises while a write is running, the write is aborted. The target byte is left erased and a sticky error flag is raised. Software clears that flag by writing 0 to its bit.

The sequencer is a three-state machine:
- `ST_IDLE` to `ST_ERASE` on an accepted write.
- `ST_ERASE` to `ST_PROG` when the erase count expires, which writes 0xFF to the target.
- `ST_PROG` to `ST_IDLE` when the program count expires, which writes the data.
- `ST_ERASE` or `ST_PROG` to `ST_IDLE` when brown-out is seen (abort), which writes 0xFF to the target and sets the error flag.

Control register layout, read through `ctl_rd_data`:

| Bit | Meaning |
|-----|---------|
| 0 | busy |
| 1 | enable |
| 2 | error |
| 3 | inhibit |
| 7:4 | read 0 |

Top module: `nvm_write_seq`

## Requirements
- R1: `xd_hit` is 1 exactly when the enable bit (control bit 1, loaded from `ctl_wdata[1]` on a control write) is set and `xd_addr` is below 0x1000.
- R2: A write with `xd_hit` high, while not busy, not inhibited and with `bod_i` low, is accepted at that clock edge. Busy (control bit 0) reads 1 from the next cycle on.
- R3: After acceptance, busy stays 1 for exactly ERASE_CYC + PROG_CYC cycles. After that, a read of the target returns the written byte.
- R4: While busy is 1, array reads return 0xFF and array writes are ignored; the stored contents are unchanged.
- R5: Inhibit (control bit 3) is 1 for GUARD_CYC cycles after reset, and for GUARD_CYC cycles after the last cycle with `bod_i` high. No write is accepted while inhibit or `bod_i` is 1.
- R6: If `bod_i` is 1 at a clock edge while busy, the write is aborted: busy is 0 and error (control bit 2) is 1 in the next cycle, and the target location then reads 0xFF.
- R7: Error stays 1 until a control write with `ctl_wdata[2]` = 0. A control write with `ctl_wdata[2]` = 1 leaves it unchanged.
- R8: A read that hits the array while not busy places the stored byte on `xd_rdata` in the next cycle. The value is held until the next read.
- R9: After reset, the control register reads 0x08 (only inhibit set), and `xd_rdata` reads 0xFF.
- R10: A write while disabled, or at an address of 0x1000 or above, leaves the array and busy unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bod_i | input | 1 | Brown-out condition, high while supply is low |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rd_data | output | 8 | Control/status register contents |
| xd_addr | input | 16 | External-data address |
| xd_rd | input | 1 | External-data read strobe |
| xd_wr | input | 1 | External-data write strobe |
| xd_wdata | input | 8 | External-data write data |
| xd_hit | output | 1 | Access is claimed by the array |
| xd_rdata | output | 8 | Registered read data |

## Verification
The hardest situation to reach is a brown-out that lands inside a running write. It must hit either the erase phase or the program phase, and then its after-effects must be told apart: the erased byte, the sticky error, and the renewed inhibit window that refuses the next write. The stimulus counts cycles from the accepting edge to place a one-cycle brown-out pulse in each phase separately. It then issues a write during the renewed inhibit window, and clears the error flag with both bit values. A behavioural model with a per-byte array and remaining-cycle counters is compared against every output on every clock.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_PROG  = 2'd2
    } nvm_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/nvm_guard_timer.sv
module nvm_guard_timer #(
    parameter int GUARD_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bod_i,
    output logic inhibit_o
);
    localparam int CW = $clog2(GUARD_CYC + 1);

    logic [CW-1:0] left_q;

    // reloads on reset and on every brown-out cycle, then counts down to zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= CW'(GUARD_CYC);
        end else if (bod_i) begin
            left_q <= CW'(GUARD_CYC);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign inhibit_o = (left_q != '0);
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
    parameter int DEPTH  = 4096,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] wa,
    input  logic [DATA_W-1:0]        wd,
    input  logic [$clog2(DEPTH)-1:0] ra,
    output logic [DATA_W-1:0]        rd
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[wa] <= wd;
        end
    end

    assign rd = cells[ra];
endmodule

// File: rtl/nvm_write_seq.sv
module nvm_write_seq
    import nvm_pkg::*;
#(
    parameter int XA_W      = 16,
    parameter int DEPTH     = 4096,
    parameter int CLK_KHZ   = 50000,
    parameter int GUARD_US  = 2000,
    parameter int ERASE_CYC = 100000,
    parameter int PROG_CYC  = 100000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bod_i,
    input  logic            ctl_wr,
    input  logic [7:0]      ctl_wdata,
    output logic [7:0]      ctl_rd_data,
    input  logic [XA_W-1:0] xd_addr,
    input  logic            xd_rd,
    input  logic            xd_wr,
    input  logic [7:0]      xd_wdata,
    output logic            xd_hit,
    output logic [7:0]      xd_rdata
);
    localparam int IDX_W     = $clog2(DEPTH);
    localparam int GUARD_CYC = CLK_KHZ * GUARD_US / 1000;
    localparam int LONGEST   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W     = $clog2(LONGEST + 1);

    nvm_state_e       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [IDX_W-1:0] tgt_q;
    logic [7:0]       dat_q;
    logic             en_q, err_q;
    logic [7:0]       rdata_q;

    logic             inhibit;
    logic             in_win, accept, busy;
    logic             ev_erased, ev_programmed, ev_abort;
    logic             mem_we;
    logic [7:0]       mem_wd, mem_rd;

    nvm_guard_timer #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .bod_i     (bod_i),
        .inhibit_o (inhibit)
    );

    nvm_cell_array #(.DEPTH(DEPTH), .DATA_W(8)) u_cells (
        .clk (clk),
        .we  (mem_we),
        .wa  (tgt_q),
        .wd  (mem_wd),
        .ra  (xd_addr[IDX_W-1:0]),
        .rd  (mem_rd)
    );

    assign in_win = (xd_addr < XA_W'(DEPTH));
    assign xd_hit = en_q && in_win;
    assign busy   = (st_q != ST_IDLE);
    assign accept = xd_hit && xd_wr && !busy && !inhibit && !bod_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // next state and phase events
    always_comb begin
        st_n          = st_q;
        cnt_n         = cnt_q;
        ev_erased     = 1'b0;
        ev_programmed = 1'b0;
        ev_abort      = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    st_n  = ST_ERASE;
                    cnt_n = CNT_W'(ERASE_CYC - 1);
                end
            end
            ST_ERASE: begin
                if (bod_i) begin
                    ev_abort = 1'b1;
                    st_n     = ST_IDLE;
                end else if (cnt_q == '0) begin
                    ev_erased = 1'b1;
                    st_n      = ST_PROG;
                    cnt_n     = CNT_W'(PROG_CYC - 1);
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            ST_PROG: begin
                if (bod_i) begin
                    ev_abort = 1'b1;
                    st_n     = ST_IDLE;
                end else if (cnt_q == '0) begin
                    ev_programmed = 1'b1;
                    st_n          = ST_IDLE;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // outputs toward the array and the status register
    always_comb begin
        mem_we      = ev_erased || ev_programmed || ev_abort;
        mem_wd      = ev_programmed ? dat_q : ERASED_BYTE;
        ctl_rd_data = {4'b0000, inhibit, err_q, en_q, busy};
    end

    // captured write target, control bits and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q   <= '0;
            dat_q   <= '0;
            en_q    <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= ERASED_BYTE;
        end else begin
            if (accept) begin
                tgt_q <= xd_addr[IDX_W-1:0];
                dat_q <= xd_wdata;
            end
            if (ctl_wr) begin
                en_q <= ctl_wdata[1];
            end
            if (ev_abort) begin
                err_q <= 1'b1;
            end else if (ctl_wr && !ctl_wdata[2]) begin
                err_q <= 1'b0;
            end
            if (xd_rd) begin
                rdata_q <= (xd_hit && !busy) ? mem_rd : ERASED_BYTE;
            end
        end
    end

    assign xd_rdata = rdata_q;
endmodule

// File: rtl/nvm_write_seq_sva.sv
module nvm_write_seq_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       bod_i,
    input logic       ctl_wr,
    input logic [7:0] ctl_wdata,
    input logic [7:0] ctl_rd_data,
    input logic       xd_hit,
    input logic       xd_rd,
    input logic       xd_wr,
    input logic [7:0] xd_rdata
);
    logic busy, err, inh;
    assign busy = ctl_rd_data[0];
    assign err  = ctl_rd_data[2];
    assign inh  = ctl_rd_data[3];

    a_r2_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (xd_hit && xd_wr && !busy && !inh && !bod_i) |=> busy);

    a_r5_refuse_when_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (inh || bod_i)) |=> !busy);

    a_r5_bod_raises_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        bod_i |=> inh);

    a_r6_abort_on_bod: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bod_i) |=> (!busy && err));

    a_r7_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(ctl_wr && !ctl_wdata[2])) |=> err);

    a_r7_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_wdata[2] && !(busy && bod_i)) |=> !err);

    a_r4_busy_read_erased: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xd_rd) |=> (xd_rdata == 8'hFF));

    a_r9_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_data[7:4] == 4'b0000);
endmodule

bind nvm_write_seq nvm_write_seq_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .bod_i       (bod_i),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .ctl_rd_data (ctl_rd_data),
    .xd_hit      (xd_hit),
    .xd_rd       (xd_rd),
    .xd_wr       (xd_wr),
    .xd_rdata    (xd_rdata)
);

// File: tb/nvm_write_seq_tb_top.sv
`timescale 1ns/1ps
module nvm_write_seq_tb_top;
    localparam int E  = 6;
    localparam int P  = 5;
    localparam int KHZ = 10;
    localparam int GUS = 2000;
    localparam int G  = KHZ * GUS / 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bod_i = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic [7:0]  ctl_rd_data;
    logic [15:0] xd_addr = 16'h0000;
    logic        xd_rd = 1'b0;
    logic        xd_wr = 1'b0;
    logic [7:0]  xd_wdata = 8'h00;
    logic        xd_hit;
    logic [7:0]  xd_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nvm_write_seq #(
        .XA_W(16), .DEPTH(4096), .CLK_KHZ(KHZ), .GUARD_US(GUS),
        .ERASE_CYC(E), .PROG_CYC(P)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bod_i(bod_i),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rd_data(ctl_rd_data),
        .xd_addr(xd_addr), .xd_rd(xd_rd), .xd_wr(xd_wr), .xd_wdata(xd_wdata),
        .xd_hit(xd_hit), .xd_rdata(xd_rdata)
    );

    // behavioural reference model
    logic [7:0] m_mem [4096];
    bit         m_known [4096];
    int         m_left, m_guard, m_ta;
    bit         m_en, m_err;
    logic [7:0] m_td, m_rd;

    initial begin
        for (int i = 0; i < 4096; i++) m_known[i] = 1'b0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_guard = G; m_en = 0; m_err = 0; m_rd = 8'hFF;
        end else begin
            bit hit, acc, abort;
            int a;
            a     = int'(xd_addr);
            hit   = m_en && (a < 4096);
            acc   = hit && xd_wr && (m_left == 0) && (m_guard == 0) && !bod_i;
            abort = 1'b0;
            if (xd_rd) m_rd = (hit && m_left == 0) ? m_mem[a] : 8'hFF;
            if (m_left > 0) begin
                if (bod_i) begin
                    abort = 1'b1; m_left = 0;
                    m_mem[m_ta] = 8'hFF; m_known[m_ta] = 1'b1;
                end else begin
                    m_left--;
                    if (m_left == P) m_mem[m_ta] = 8'hFF;
                    if (m_left == 0) begin m_mem[m_ta] = m_td; m_known[m_ta] = 1'b1; end
                end
            end else if (acc) begin
                m_left = E + P; m_ta = a; m_td = xd_wdata;
            end
            if (bod_i) m_guard = G; else if (m_guard > 0) m_guard--;
            if (abort) m_err = 1'b1;
            else if (ctl_wr && !ctl_wdata[2]) m_err = 1'b0;
            if (ctl_wr) m_en = ctl_wdata[1];
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the model, away from the edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            chk("R2 busy",    {7'd0, ctl_rd_data[0]}, {7'd0, m_left > 0});
            chk("R1 enable",  {7'd0, ctl_rd_data[1]}, {7'd0, m_en});
            chk("R7 error",   {7'd0, ctl_rd_data[2]}, {7'd0, m_err});
            chk("R5 inhibit", {7'd0, ctl_rd_data[3]}, {7'd0, m_guard > 0});
            chk("R1 hit",     {7'd0, xd_hit}, {7'd0, m_en && (int'(xd_addr) < 4096)});
            chk("R8 rdata",   xd_rdata, m_rd);
        end
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic cpu_ctl(input logic [7:0] d);
        step(); ctl_wr = 1'b1; ctl_wdata = d;
        step(); ctl_wr = 1'b0;
    endtask

    task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
        step(); xd_wr = 1'b1; xd_addr = a; xd_wdata = d;
        step(); xd_wr = 1'b0;
    endtask

    task automatic cpu_rd(input logic [15:0] a);
        step(); xd_rd = 1'b1; xd_addr = a;
        step(); xd_rd = 1'b0;
    endtask

    task automatic bod_pulse();
        step(); bod_i = 1'b1;
        step(); bod_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (ctl_rd_data[0]) step();
    endtask

    task automatic wait_clear();
        while (ctl_rd_data[3]) step();
    endtask

    initial begin
        int n;
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R9 reset status", ctl_rd_data, 8'h08);
        chk("R9 reset rdata", xd_rdata, 8'hFF);

        cpu_ctl(8'h02);
        cpu_wr(16'h0010, 8'h11);
        chk("R5 write refused while inhibited", {7'd0, ctl_rd_data[0]}, 8'h00);
        wait_clear();

        cpu_wr(16'h0123, 8'hA5);
        chk("R2 busy after accept", {7'd0, ctl_rd_data[0]}, 8'h01);
        n = 0;
        while (ctl_rd_data[0]) begin n++; step(); end
        chk("R3 busy length", 8'(n), 8'(E + P));
        cpu_rd(16'h0123);
        chk("R3 R8 programmed value", xd_rdata, 8'hA5);

        cpu_wr(16'h0FFF, 8'h5A);
        cpu_rd(16'h0FFF);
        chk("R4 read while busy", xd_rdata, 8'hFF);
        cpu_wr(16'h0FFF, 8'h77);
        wait_idle();
        cpu_rd(16'h0FFF);
        chk("R4 write while busy ignored", xd_rdata, 8'h5A);

        cpu_ctl(8'h00);
        cpu_wr(16'h0123, 8'h00);
        chk("R10 disabled write", {7'd0, ctl_rd_data[0]}, 8'h00);
        cpu_ctl(8'h02);
        cpu_wr(16'h1000, 8'h99);
        chk("R10 out of window write", {7'd0, ctl_rd_data[0]}, 8'h00);
        cpu_rd(16'h0123);
        chk("R10 array unchanged", xd_rdata, 8'hA5);

        cpu_wr(16'h0200, 8'h42);
        repeat (E + 1) step();
        bod_pulse();
        chk("R6 abort in program phase", ctl_rd_data, 8'h0E);
        cpu_rd(16'h0200);
        chk("R6 aborted byte erased", xd_rdata, 8'hFF);
        cpu_wr(16'h0300, 8'h01);
        chk("R5 refused after brown-out", {7'd0, ctl_rd_data[0]}, 8'h00);
        wait_clear();

        cpu_ctl(8'h06);
        chk("R7 writing one keeps error", {7'd0, ctl_rd_data[2]}, 8'h01);
        cpu_ctl(8'h02);
        chk("R7 writing zero clears error", {7'd0, ctl_rd_data[2]}, 8'h00);

        cpu_wr(16'h0123, 8'h00);
        bod_pulse();
        chk("R6 abort in erase phase", {7'd0, ctl_rd_data[2]}, 8'h01);
        cpu_rd(16'h0123);
        chk("R6 erase-phase abort byte", xd_rdata, 8'hFF);
        wait_clear();

        cpu_wr(16'h0300, 8'hC3);
        wait_idle();
        cpu_rd(16'h0300);
        chk("R3 write after recovery", xd_rdata, 8'hC3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule